// File: doc/BRIEF.md
# Auxiliary ADC Conversion Sequencer

This block schedules conversions on one shared 12-bit auxiliary converter that serves five selectable input sources. Software programs a control word (master enable, conversion enable, sleep enable, rate) and a source mask through a small register port. Each trigger runs exactly one conversion, on the next enabled source after the one measured last, so covering N enabled sources takes N triggers.

A rate of zero selects manual mode. In manual mode each write of 1 to the conversion-enable bit starts a single conversion, and the block clears the bit itself when that conversion ends. A nonzero rate selects automatic mode. In automatic mode the bit stays set and a counter fires a trigger every rate × TICK clock cycles.

The block talks to the converter through a start pulse with a channel number, and gets back a done strobe with a 12-bit code. It latches the code with its source tag and pulses an interrupt. Two power-state inputs gate it. The off state clears the master enable. The sleep state stops conversions unless sleep operation has been allowed.

Top module: `aux_conv_sched`

## Requirements
- R1: After reset, the control word (address 0) and the source mask (address 1) read 0, and `irq` and `adc_start` are low.
- R2: The control word holds the master enable at bit 15, the conversion enable at bit 14, the sleep enable at bit 12 and the rate at bits 7:0. All other bits read 0. Bit i of the source mask (bits 4:0) enables source i. Both registers read back what was written.
- R3: With rate 0, writing 1 to bit 14 starts one conversion. Bit 14 reads 0 from the cycle in which `irq` pulses.
- R4: Each trigger converts the first enabled source after the last converted one, in cyclic index order; after reset the search starts at source 0. With mask 01101 the order is 0, 2, 3, 0.
- R5: Each trigger issues exactly one `adc_start`.
- R6: With a nonzero rate and bit 14 set, `adc_start` pulses every rate × TICK cycles, and bit 14 stays 1.
- R7: `irq` is a one-cycle pulse in the cycle after `adc_done`. From that same cycle, address 2 reads the source tag in bits 14:12 and the 12-bit code in bits 11:0.
- R8: A trigger that occurs while a conversion is in progress is dropped and not queued.
- R9: With an empty source mask, a trigger gives no `adc_start` and no `irq`. In manual mode it clears bit 14 at once.
- R10: While `pwr_off` is high, the master enable is forced to 0, so no conversion starts.
- R11: While `pwr_sleep` is high, no conversion starts unless the sleep enable is 1. In that case operation follows the master enable.
- R12: `adc_start` is a one-cycle pulse, and `adc_chan` names an enabled source while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 source mask, 2 result |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pwr_off | input | 1 | Off power state |
| pwr_sleep | input | 1 | Sleep power state |
| adc_start | output | 1 | Start-conversion pulse |
| adc_chan | output | 3 | Source to convert |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | 12 | Conversion code |
| irq | output | 1 | Result-ready pulse |

## Verification
A wrong round-robin pointer shows up as a wrong tag at address 2 on the very next interrupt. A stuck busy flag shows up as missing `adc_start` pulses within one trigger period. A manual-mode enable bit that fails to clear shows up at once as a second start pulse, a few cycles after the first conversion ends. A counter with the wrong length moves the spacing between automatic start pulses away from rate × TICK on the first measured interval.

// File: rtl/aux_conv_sched.sv
module aux_conv_sched #(
  parameter int NSRC   = 5,
  parameter int DW     = 12,
  parameter int RATE_W = 8,
  parameter int TICK   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                addr,
  input  logic [15:0]               wdata,
  output logic [15:0]               rdata,
  input  logic                      pwr_off,
  input  logic                      pwr_sleep,
  output logic                      adc_start,
  output logic [$clog2(NSRC)-1:0]   adc_chan,
  input  logic                      adc_done,
  input  logic [DW-1:0]             adc_data,
  output logic                      irq
);
  localparam int CW = $clog2(NSRC);
  localparam int PW = RATE_W + $clog2(TICK) + 1;

  logic              en, cvt, slp, busy;
  logic [RATE_W-1:0] rate;
  logic [NSRC-1:0]   src_en;
  logic [CW-1:0]     last, nxt, res_tag;
  logic [DW-1:0]     res_data;
  logic [PW-1:0]     cnt;
  logic              hit;

  wire manual  = (rate == '0);
  wire active  = en && !pwr_off && (!pwr_sleep || slp);
  wire [PW-1:0] period = PW'(rate) * PW'(TICK);
  wire cnt_hit = (cnt == period - PW'(1));
  wire trig    = active && cvt && !busy && (manual || cnt_hit);

  always_comb begin
    nxt = last;
    hit = 1'b0;
    for (int k = 1; k <= NSRC; k++) begin
      int j;
      j = (int'(last) + k) % NSRC;
      if (!hit && src_en[j[CW-1:0]]) begin
        nxt = j[CW-1:0];
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {en, cvt, 1'b0, slp, {(12-RATE_W){1'b0}}, rate};
      2'd1:    rdata = 16'(src_en);
      2'd2:    rdata = (16'(res_tag) << 12) | 16'(res_data);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; cvt <= 1'b0; slp <= 1'b0; rate <= '0;
      src_en <= '0; busy <= 1'b0; last <= CW'(NSRC - 1);
      adc_start <= 1'b0; adc_chan <= '0; irq <= 1'b0;
      res_tag <= '0; res_data <= '0; cnt <= '0;
    end else begin
      adc_start <= 1'b0;
      irq       <= 1'b0;
      if (wr_en && addr == 2'd0) begin
        en   <= wdata[15];
        cvt  <= wdata[14];
        slp  <= wdata[12];
        rate <= wdata[RATE_W-1:0];
      end
      if (wr_en && addr == 2'd1) src_en <= wdata[NSRC-1:0];
      if (pwr_off) en <= 1'b0;
      if (trig) begin
        if (hit) begin
          busy      <= 1'b1;
          adc_start <= 1'b1;
          adc_chan  <= nxt;
          last      <= nxt;
        end else if (manual) begin
          cvt <= 1'b0;
        end
      end
      if (busy && adc_done) begin
        busy     <= 1'b0;
        irq      <= 1'b1;
        res_tag  <= adc_chan;
        res_data <= adc_data;
        if (manual) cvt <= 1'b0;
      end
      if (!(active && cvt && !manual) || cnt_hit) cnt <= '0;
      else cnt <= cnt + PW'(1);
    end
  end

  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r12_chan_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($past(src_en) & (NSRC'(1) << adc_chan)) != '0);
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !$past(busy));
  a_r7_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(adc_done));
  a_r3_manual_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(rate == '0)) |-> !cvt);
  a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> !en);
  a_r11_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(!pwr_sleep || slp));
endmodule

// File: tb/aux_conv_sched_test.sv
module aux_conv_sched_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pwr_off = 1'b0, pwr_sleep = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic adc_start, adc_done = 1'b0, irq;
  logic [2:0] adc_chan;
  logic [11:0] adc_data = '0;
  int checks = 0, errors = 0, cyc = 0, nstart = 0, nirq = 0, t_prev = 0, t_last = 0;
  int lat = 3, scnt = 0;

  always #5 clk = ~clk;

  aux_conv_sched uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_off(pwr_off), .pwr_sleep(pwr_sleep), .adc_start(adc_start),
    .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data), .irq(irq));

  function automatic logic [11:0] code(input logic [2:0] c);
    return 12'h5A0 + 12'(c);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    adc_done <= 1'b0;
    if (irq) nirq <= nirq + 1;
    if (adc_start) begin
      nstart <= nstart + 1; t_prev <= t_last; t_last <= cyc;
      scnt <= lat; adc_data <= code(adc_chan);
    end else if (scnt > 0) begin
      scnt <= scnt - 1;
      if (scnt == 1) adc_done <= 1'b1;
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [7:0] VEC [8] = '{
    {5'b01101, 3'd0}, {5'b01101, 3'd2}, {5'b01101, 3'd3}, {5'b01101, 3'd0},
    {5'b10010, 3'd1}, {5'b10010, 3'd4}, {5'b10010, 3'd1}, {5'b00001, 3'd0}};

  initial begin
    logic [15:0] d;
    int s0, i0, seen;
    #1; idle(2); rst_n = 1'b1; @(negedge clk);
    rd(2'd0, d); chk("R1 ctrl reset", d, 0);
    rd(2'd1, d); chk("R1 src reset", d, 0);
    chk("R1 irq/start reset", {irq, adc_start}, 0);

    wr(2'd0, 16'h10A5); rd(2'd0, d); chk("R2 ctrl readback", d, 16'h10A5);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0013); rd(2'd1, d); chk("R2 src readback", d, 16'h0013);

    foreach (VEC[v]) begin
      wr(2'd1, 16'(VEC[v][7:3]));
      s0 = nstart; seen = 0;
      wr(2'd0, 16'hC000);
      for (int t = 0; t < 40 && !seen; t++) begin
        @(negedge clk);
        if (irq) begin
          seen = 1;
          rd(2'd2, d);
          chk("R4/R7 result tag", d[14:12], VEC[v][2:0]);
          chk("R7 result code", d[11:0], code(VEC[v][2:0]));
          rd(2'd0, d); chk("R3 cvt self-clear", d[14], 0);
        end
      end
      chk("R7 irq seen", seen, 1);
      idle(8);
      chk("R5 one start per trigger", nstart - s0, 1);
    end

    wr(2'd1, 16'h0001);
    wr(2'd0, 16'hC003);
    s0 = nstart; while (nstart < s0 + 3) @(negedge clk);
    chk("R6 auto period", t_last - t_prev, 12);
    rd(2'd0, d); chk("R6 cvt stays set", d[14], 1);
    wr(2'd0, 16'hC001);
    s0 = nstart; while (nstart < s0 + 3) @(negedge clk);
    chk("R8 busy trigger dropped", t_last - t_prev, 8);
    wr(2'd0, 16'h0000); idle(10);

    wr(2'd1, 16'h0000);
    s0 = nstart; i0 = nirq;
    wr(2'd0, 16'hC000); idle(1);
    rd(2'd0, d); chk("R9 empty mask clears cvt", d[14], 0);
    idle(10);
    chk("R9 no start/irq", (nstart - s0) + (nirq - i0), 0);

    wr(2'd1, 16'h0004);
    pwr_sleep = 1'b1;
    s0 = nstart;
    wr(2'd0, 16'hC000); idle(20);
    chk("R11 sleep blocks", nstart - s0, 0);
    wr(2'd0, 16'hD000); idle(20);
    chk("R11 sleep enable allows", nstart - s0, 1);
    pwr_sleep = 1'b0;

    s0 = nstart;
    @(negedge clk); pwr_off = 1'b1;
    wr(2'd0, 16'hC000); idle(1);
    rd(2'd0, d); chk("R10 off clears enable", d[15], 0);
    idle(20);
    chk("R10 off no start", nstart - s0, 0);
    pwr_off = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule